// File: doc/BRIEF.md
# Cascaded Shift-Based Smoothing Filter

This block smooths a signed fixed-point trajectory signal that arrives as steps or as a coarse approximation. It chains a parameterised number of identical first-order low-pass stages. On each enabled clock, every stage moves its state toward its own input by a power-of-two fraction of the gap between them. The scaling is an arithmetic right shift, so the chain needs no multiplier. Each stage holds a state register that is wider than the sample by a set number of fractional bits, and this keeps the small per-step moves from being lost. Each extra stage makes one more derivative of the output smooth.

A per-clock operation is decoded from the two control inputs. There are three named operations. HOLD leaves every state unchanged. STEP applies one filter update to all stages at once, with every stage using the values it had before the edge. LOAD writes the preload value into every stage. The operation is chosen again on every clock with no stored history: preload selects LOAD; otherwise enable selects STEP; otherwise HOLD applies. LOAD lets a trajectory begin at a chosen value with no start-up transient. The output of the last stage is the block result, and the output of every stage can also be brought out on a tap bus.

Top module: `smooth_chain`

## Requirements
- R1: After reset, every stage state is zero, so `smooth_out` and every tap read zero.
- R2: On a STEP clock, each stage state S (DATA_W+FRAC_W bits, signed) becomes S + ((X − S) >>> SHIFT). The difference X − S is formed one bit wider, and >>> rounds toward minus infinity. For stage 0, X is `sample_in` with FRAC_W zero bits appended below it.
- R3: When `enable` and `preload` are both low (HOLD), every stage state keeps its value, whatever `sample_in` does.
- R4: A STEP never carries a state past its input. When X ≥ S, the new state lies in [S, X]. When X < S, the new state is strictly below S and not below X.
- R5: When `preload` is high (LOAD), every stage state becomes `preload_val` with FRAC_W zero fraction bits, whatever `enable` is. The result shows on the outputs after that edge.
- R6: Each output is the upper DATA_W bits of its stage state, which is the floor of the state divided by 2^FRAC_W.
- R7: For stage i > 0, X is the full-width state of stage i−1 as it was before the edge.
- R8: Under a constant input held long enough, `smooth_out` settles at the input value or one LSB below it. When approached from above, it settles exactly on the input value.
- R9: Tap i sits at bits [i*DATA_W +: DATA_W] of `stage_taps`, and tap STAGES−1 equals `smooth_out`. When EXPOSE_TAPS is 0, the bus is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Selects STEP when preload is low |
| preload | input | 1 | Selects LOAD; takes priority over enable |
| preload_val | input | DATA_W | Value written into every stage on LOAD |
| sample_in | input | DATA_W | Signed input sample |
| smooth_out | output | DATA_W | Output of the last stage |
| stage_taps | output | STAGES*DATA_W | Output of every stage, stage 0 in the lowest bits |

## Verification
A wrong stage state is visible at its tap on the clock after the bad update, because every output is a plain slice of its state. Once the error reaches the later stages, it spreads to the last stage within at most STAGES clocks. Lost fractional bits or a wrong rounding direction tend to show much later, as a settled value off by more than one LSB or as a step that overshoots its input. For that reason the bench compares every tap with an exact model on every clock, and it also checks the settled values and the direction of each move.

// File: rtl/smooth_pkg.sv
package smooth_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } stage_op_e;
endpackage

// File: rtl/smooth_stage.sv
module smooth_stage
    import smooth_pkg::*;
#(
    parameter int STATE_W = 24,
    parameter int SHIFT   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  stage_op_e                 op,
    input  logic signed [STATE_W-1:0] load_val,
    input  logic signed [STATE_W-1:0] din,
    output logic signed [STATE_W-1:0] state_q
);
    localparam int DIFF_W = STATE_W + 1;

    logic signed [DIFF_W-1:0]  gap;
    logic signed [DIFF_W-1:0]  nudge;
    logic signed [STATE_W-1:0] state_d;

    // One bit of headroom for the gap; the nudge magnitude never exceeds it.
    always_comb begin
        gap   = DIFF_W'(din) - DIFF_W'(state_q);
        nudge = gap >>> SHIFT;
        unique case (op)
            OP_STEP: state_d = state_q + STATE_W'(nudge);
            OP_LOAD: state_d = load_val;
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(state_q));

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (state_q == $past(load_val)));

    assert_no_overshoot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP) |=>
            (($past(din) >= $past(state_q)) ?
                (state_q >= $past(state_q) && state_q <= $past(din)) :
                (state_q <  $past(state_q) && state_q >= $past(din))));
endmodule

// File: rtl/smooth_chain.sv
module smooth_chain
    import smooth_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int FRAC_W      = 8,
    parameter int SHIFT       = 3,
    parameter int STAGES      = 3,
    parameter bit EXPOSE_TAPS = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     preload,
    input  logic [DATA_W-1:0]        preload_val,
    input  logic [DATA_W-1:0]        sample_in,
    output logic [DATA_W-1:0]        smooth_out,
    output logic [STAGES*DATA_W-1:0] stage_taps
);
    localparam int STATE_W = DATA_W + FRAC_W;

    stage_op_e                 op;
    logic signed [STATE_W-1:0] sample_ext;
    logic signed [STATE_W-1:0] load_ext;
    logic signed [STATE_W-1:0] chain_in [STAGES];
    logic signed [STATE_W-1:0] st       [STAGES];

    always_comb begin
        unique case ({preload, enable})
            2'b00:   op = OP_HOLD;
            2'b01:   op = OP_STEP;
            2'b10:   op = OP_LOAD;
            2'b11:   op = OP_LOAD;
            default: op = OP_HOLD;
        endcase
    end

    assign sample_ext = {sample_in,   {FRAC_W{1'b0}}};
    assign load_ext   = {preload_val, {FRAC_W{1'b0}}};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_in[g] = sample_ext;
        end else begin : g_next
            assign chain_in[g] = st[g-1];
        end

        smooth_stage #(.STATE_W(STATE_W), .SHIFT(SHIFT)) stage_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .op       (op),
            .load_val (load_ext),
            .din      (chain_in[g]),
            .state_q  (st[g])
        );

        if (EXPOSE_TAPS) begin : g_tap
            assign stage_taps[g*DATA_W +: DATA_W] = st[g][STATE_W-1:FRAC_W];
        end else begin : g_notap
            assign stage_taps[g*DATA_W +: DATA_W] = '0;
        end
    end

    assign smooth_out = st[STAGES-1][STATE_W-1:FRAC_W];

    assert_preload_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        preload |=> (smooth_out == $past(preload_val)));

    assert_hold_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!preload && !enable) |=> $stable(smooth_out));
endmodule

// File: tb/smooth_chain_tb_top.sv
module smooth_chain_tb_top;
    localparam int DATA_W = 16;
    localparam int FRAC_W = 8;
    localparam int SHIFT  = 3;
    localparam int STAGES = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic preload = 1'b0;
    logic [DATA_W-1:0] preload_val = '0;
    logic [DATA_W-1:0] sample_in = '0;
    logic [DATA_W-1:0] smooth_out;
    logic [STAGES*DATA_W-1:0] stage_taps;

    int checks = 0;
    int errors = 0;
    longint st [STAGES];

    always #4 clk = ~clk;

    smooth_chain #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .SHIFT(SHIFT),
                   .STAGES(STAGES), .EXPOSE_TAPS(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .preload(preload),
        .preload_val(preload_val), .sample_in(sample_in),
        .smooth_out(smooth_out), .stage_taps(stage_taps));

    function automatic logic [DATA_W-1:0] out_of(longint s);
        return DATA_W'(s >>> FRAC_W);
    endfunction

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, $signed(act), $signed(exp));
        end
    endtask

    // Compare every tap and the final output against the model (R6, R7, R9).
    task automatic compare_all(string tag);
        for (int i = 0; i < STAGES; i++)
            check(tag, stage_taps[i*DATA_W +: DATA_W], out_of(st[i]));
        check({tag, "/R9 last tap"}, smooth_out, out_of(st[STAGES-1]));
    endtask

    // Drive at the falling edge, advance the model at the rising edge, compare after it.
    task automatic cycle(logic en, logic pl, logic [DATA_W-1:0] pv,
                         logic [DATA_W-1:0] smp, string tag);
        longint nxt [STAGES];
        longint x;
        enable = en; preload = pl; preload_val = pv; sample_in = smp;
        @(posedge clk);
        for (int i = 0; i < STAGES; i++) begin
            x = (i == 0) ? longint'($signed(smp)) * 256 : st[i-1];
            if (pl)      nxt[i] = longint'($signed(pv)) * 256;
            else if (en) nxt[i] = st[i] + ((x - st[i]) >>> SHIFT);
            else         nxt[i] = st[i];
        end
        for (int i = 0; i < STAGES; i++) st[i] = nxt[i];
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] prev;
        for (int i = 0; i < STAGES; i++) st[i] = 0;
        repeat (3) @(negedge clk);
        compare_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1 after release");

        // R3: hold with an active sample does nothing
        for (int n = 0; n < 10; n++) cycle(1'b0, 1'b0, 16'd0, 16'd5000, "R3 hold");
        check("R3 hold out", smooth_out, 16'd0);

        // R2/R7/R4: rising step, tracked each clock, monotone non-decreasing output
        prev = smooth_out;
        for (int n = 0; n < 600; n++) begin
            cycle(1'b1, 1'b0, 16'd0, 16'd1000, "R2 R7 rise");
            if ($signed(smooth_out) < $signed(prev) || $signed(smooth_out) > 1000)
                check("R4 monotone rise", smooth_out, prev);
            else checks++;
            prev = smooth_out;
        end
        // R8: settle within one LSB below
        if ($signed(smooth_out) == 1000 || $signed(smooth_out) == 999) checks++;
        else check("R8 settle from below", smooth_out, 16'd1000);

        // R3: hold mid-transient keeps all taps
        cycle(1'b1, 1'b0, 16'd0, -16'sd300, "R2 fall");
        prev = smooth_out;
        for (int n = 0; n < 5; n++) cycle(1'b0, 1'b0, 16'd7, 16'd4000, "R3 hold mid");
        check("R3 hold mid out", smooth_out, prev);

        // R4/R8 falling: settle exactly from above
        for (int n = 0; n < 700; n++) begin
            cycle(1'b1, 1'b0, 16'd0, -16'sd300, "R2 R7 fall");
            if ($signed(smooth_out) > $signed(prev) || $signed(smooth_out) < -300)
                check("R4 monotone fall", smooth_out, prev);
            else checks++;
            prev = smooth_out;
        end
        check("R8 settle from above", smooth_out, -16'sd300);

        // R5: preload wins over enable, no transient
        cycle(1'b1, 1'b1, 16'd1234, 16'd9999, "R5 preload");
        for (int i = 0; i < STAGES; i++)
            check("R5 tap preload", stage_taps[i*DATA_W +: DATA_W], 16'd1234);
        for (int n = 0; n < 20; n++) cycle(1'b1, 1'b0, 16'd0, 16'd1234, "R5 steady");
        check("R5 no transient", smooth_out, 16'd1234);

        // R2: full-scale swing, extreme differences
        cycle(1'b0, 1'b1, 16'h7fff, 16'd0, "R2 load max");
        for (int n = 0; n < 400; n++) cycle(1'b1, 1'b0, 16'd0, 16'h8000, "R2 swing");
        check("R8 settle min", smooth_out, 16'h8000);
        for (int n = 0; n < 400; n++) cycle(1'b1, 1'b0, 16'd0, 16'h7fff, "R2 swing up");

        // Varying pattern with random enables
        for (int n = 0; n < 300; n++)
            cycle(1'($urandom_range(0, 1)), 1'b0, 16'd0,
                  16'($urandom_range(0, 65535)), "R2 R3 random");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule